// File: doc/BRIEF.md
# Endian-Aware Receive Byte FIFO

This block sits between a deserializer that delivers one received byte per strobe and a DMA engine that moves 16-bit words to memory. The store holds 32 bytes as 8 entries of 4 byte lanes. Each incoming byte is steered into a lane that depends on the selected byte order, so a word read from the drain side is already in the correct order for a little-endian or a big-endian memory image. The drain side always takes one 16-bit half of an entry.

Threshold logic compares the byte occupancy with a programmed threshold and raises a DMA request. Once the request is granted, one word leaves per cycle while the read strobe is high. The burst length is either the threshold (block mode) or everything present at grant time (empty-fill mode). At the end of a packet the block pads an odd byte count to a word boundary with 0xFF and then writes the 16-bit packet status into the same store, so the status reaches memory directly behind the data. The upstream source sends no bytes during the three cycles after an end-of-packet pulse, while the pad and status bytes are being inserted. The configuration inputs are changed only while reset is held.

Top module: `rx_endian_fifo`

## Requirements
- R1: The store holds 32 bytes, and `occupancy` reports the bytes held (0 to 32). A byte offered while 32 bytes are held is discarded, and it sets `overflow`, which stays set until reset.
- R2: With `cfg_big_endian`=0, the stream bytes b0,b1 form the word {b1,b0}, with the earlier byte in bits 7:0.
- R3: With `cfg_big_endian`=1, the stream bytes b0,b1 form the word {b0,b1}, with the earlier byte in bits 15:8.
- R4: `cfg_thr_code` selects a threshold of 2, 4, 8 or 12 words for codes 0, 1, 2 and 3 (that is, 4, 8, 16 or 24 bytes), capped at 2 bytes below capacity. `dma_req` rises only when `occupancy` is strictly greater than the threshold in bytes.
- R5: Words leave only after `dma_req` has been answered by a one-cycle `dma_gnt`, one word per cycle with `rd_en` high. An `rd_en` outside a granted burst has no effect.
- R6: In block mode (`cfg_empty_fill`=0) each burst moves exactly the threshold number of words. If `occupancy` is still above the threshold afterwards, a new request follows.
- R7: In empty-fill mode (`cfg_empty_fill`=1) each burst moves every whole word held at grant time.
- R8: When `eop_valid` arrives after an odd number of stream bytes, one 0xFF fill byte is appended.
- R9: Directly after the data (and any fill byte), the `eop_status` value is stored so that it reads back as the word `eop_status` in either byte order.
- R10: After reset, `occupancy`=0, `dma_req`=0 and `overflow`=0.
- R11: `dma_req` is low in the cycle after the final word of a burst is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_big_endian | input | 1 | 1: earlier byte in the high half of each word |
| cfg_empty_fill | input | 1 | 1: bursts empty the store; 0: bursts move the threshold amount |
| cfg_thr_code | input | 2 | Threshold select (2, 4, 8 or 12 words) |
| in_valid | input | 1 | Byte strobe from the deserializer |
| in_byte | input | 8 | Received byte |
| eop_valid | input | 1 | End-of-packet pulse |
| eop_status | input | 16 | Packet status word captured with eop_valid |
| dma_req | output | 1 | Request toward the DMA engine; high until the burst ends |
| dma_gnt | input | 1 | One-cycle grant that starts a burst |
| rd_en | input | 1 | Word read strobe during a burst |
| rd_data | output | 16 | Word at the head of the store |
| occupancy | output | 6 | Bytes held |
| overflow | output | 1 | Sticky flag for a discarded write |

## Verification
On every cycle the assertions check several rules. Occupancy stays within capacity, and the overflow flag never clears. A request never rises unless the previous occupancy exceeded the threshold. A word is never read from fewer than two bytes, the pad insertion leaves the write position word-aligned, a block burst ends after exactly the threshold word count, and the request drops after the final word. The byte order of the data, the fill byte and the status words, together with the empty-fill burst length and the discard of bytes once the store is full, can be seen only by comparing the words the bench reads with its own model of the byte stream.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {WR_DATA, WR_PAD, WR_ST1, WR_ST2} wr_state_t;
  typedef enum logic [1:0] {DM_IDLE, DM_REQ, DM_BURST} dma_state_t;

  // Lane that receives the byte at stream position pos within a 4-byte entry.
  function automatic logic [1:0] lane_of(input logic [1:0] pos, input logic big);
    return big ? ~pos : pos;
  endfunction

  // Threshold in bytes for a 2-bit code, capped so it stays below capacity.
  function automatic int unsigned thr_bytes(input logic [1:0] code, input int unsigned cap);
    int unsigned words;
    int unsigned b;
    case (code)
      2'd0:    words = 2;
      2'd1:    words = 4;
      2'd2:    words = 8;
      default: words = 12;
    endcase
    b = words * 2;
    if (b > cap) b = cap;
    return b;
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int ENTRIES = 8,
  localparam int EW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [EW-1:0] wr_entry,
  input  logic [1:0]    wr_lane,
  input  logic [7:0]    wr_byte,
  input  logic [EW-1:0] rd_entry,
  input  logic          rd_half,
  output logic [15:0]   rd_word
);

  logic [7:0] lane_out [4];

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [ENTRIES];
    always_ff @(posedge clk) begin
      if (we && (wr_lane == 2'(l))) mem[wr_entry] <= wr_byte;
    end
    assign lane_out[l] = mem[rd_entry];
  end

  assign rd_word = rd_half ? {lane_out[3], lane_out[2]} : {lane_out[1], lane_out[0]};

endmodule

// File: rtl/rxf_wr.sv
module rxf_wr
  import rxf_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          big,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          eop_valid,
  input  logic [15:0]   eop_status,
  input  logic          full,
  output logic          we,
  output logic [7:0]    wbyte,
  output logic [PW-1:0] wptr,
  output logic          ovf
);

  wr_state_t   st;
  logic [15:0] stat_q;
  logic        cand_valid;
  logic        wr_fire;
  logic        wr_drop;
  logic        pad_needed;

  always_comb begin
    cand_valid = 1'b0;
    wbyte      = in_byte;
    case (st)
      WR_DATA: begin cand_valid = in_valid; wbyte = in_byte; end
      WR_PAD:  begin cand_valid = 1'b1;     wbyte = 8'hFF;   end
      WR_ST1:  begin cand_valid = 1'b1;     wbyte = big ? stat_q[15:8] : stat_q[7:0]; end
      default: begin cand_valid = 1'b1;     wbyte = big ? stat_q[7:0]  : stat_q[15:8]; end
    endcase
  end

  assign wr_fire    = cand_valid && !full;
  assign wr_drop    = cand_valid && full;
  assign we         = wr_fire;
  assign pad_needed = wptr[0] ^ wr_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= WR_DATA;
      stat_q <= '0;
      wptr   <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_fire) wptr <= wptr + PW'(1);
      if (wr_drop) ovf  <= 1'b1;
      case (st)
        WR_DATA: if (eop_valid) begin
          stat_q <= eop_status;
          st     <= pad_needed ? WR_PAD : WR_ST1;
        end
        WR_PAD:  st <= WR_ST1;
        WR_ST1:  st <= WR_ST2;
        default: st <= WR_DATA;
      endcase
    end
  end

  // R1: a discarded write raises the flag, and the flag never clears
  a_r1_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> ovf);
  a_r1_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R8: the status bytes always begin on a word boundary
  a_r8_status_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WR_ST1) |-> (!wptr[0] || ovf));

endmodule

// File: rtl/rxf_dma.sv
module rxf_dma
  import rxf_pkg::*;
#(
  parameter int PW      = 6,
  parameter int DEPTH_B = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          empty_fill,
  input  logic [1:0]    thr_code,
  input  logic [PW-1:0] occ,
  input  logic          dma_gnt,
  input  logic          rd_en,
  output logic          dma_req,
  output logic          rd_fire,
  output logic [PW-1:0] rptr
);

  dma_state_t    st;
  logic [PW-1:0] thr;
  logic [PW-1:0] remain;
  logic [PW-1:0] done_cnt;
  logic          above;
  logic          last_word;

  assign thr       = PW'(thr_bytes(thr_code, DEPTH_B - 2));
  assign above     = occ > thr;
  assign dma_req   = (st != DM_IDLE);
  assign rd_fire   = (st == DM_BURST) && rd_en;
  assign last_word = rd_fire && (remain == PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= DM_IDLE;
      remain   <= '0;
      done_cnt <= '0;
      rptr     <= '0;
    end else begin
      case (st)
        DM_IDLE: if (above) st <= DM_REQ;
        DM_REQ: if (dma_gnt) begin
          st       <= DM_BURST;
          remain   <= empty_fill ? (occ >> 1) : (thr >> 1);
          done_cnt <= '0;
        end
        default: if (rd_fire) begin
          remain   <= remain - PW'(1);
          done_cnt <= done_cnt + PW'(1);
          rptr     <= rptr + PW'(2);
          if (last_word) st <= DM_IDLE;
        end
      endcase
    end
  end

  // R4: a request only ever rises after occupancy exceeded the threshold
  a_r4_req_above: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(occ > thr));
  // R5: a word is never taken from fewer than two held bytes
  a_r5_word_present: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> (occ >= PW'(2)));
  // R6: a block burst ends after exactly the threshold word count
  a_r6_block_len: assert property (@(posedge clk) disable iff (!rst_n)
    (last_word && !empty_fill) |-> (done_cnt == (thr >> 1) - PW'(1)));
  // R11: the request is low after the final word
  a_r11_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> !dma_req);

endmodule

// File: rtl/rx_endian_fifo.sv
module rx_endian_fifo
  import rxf_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_big_endian,
  input  logic                         cfg_empty_fill,
  input  logic [1:0]                   cfg_thr_code,
  input  logic                         in_valid,
  input  logic [7:0]                   in_byte,
  input  logic                         eop_valid,
  input  logic [15:0]                  eop_status,
  output logic                         dma_req,
  input  logic                         dma_gnt,
  input  logic                         rd_en,
  output logic [15:0]                  rd_data,
  output logic [$clog2(ENTRIES*4):0]   occupancy,
  output logic                         overflow
);

  localparam int DEPTH_B = ENTRIES * 4;
  localparam int PW      = $clog2(DEPTH_B) + 1;
  localparam int EW      = $clog2(ENTRIES);

  logic [PW-1:0] wptr;
  logic [PW-1:0] rptr;
  logic [PW-1:0] occ;
  logic          full;
  logic          we;
  logic [7:0]    wbyte;
  logic          rd_fire;
  logic [1:0]    wr_lane;
  logic          rd_half;

  assign occ       = wptr - rptr;
  assign full      = (occ == PW'(DEPTH_B));
  assign occupancy = occ;
  assign wr_lane   = lane_of(wptr[1:0], cfg_big_endian);
  assign rd_half   = cfg_big_endian ? ~rptr[1] : rptr[1];

  rxf_wr #(.PW(PW)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .big        (cfg_big_endian),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .eop_valid  (eop_valid),
    .eop_status (eop_status),
    .full       (full),
    .we         (we),
    .wbyte      (wbyte),
    .wptr       (wptr),
    .ovf        (overflow)
  );

  rxf_dma #(.PW(PW), .DEPTH_B(DEPTH_B)) u_dma (
    .clk        (clk),
    .rst_n      (rst_n),
    .empty_fill (cfg_empty_fill),
    .thr_code   (cfg_thr_code),
    .occ        (occ),
    .dma_gnt    (dma_gnt),
    .rd_en      (rd_en),
    .dma_req    (dma_req),
    .rd_fire    (rd_fire),
    .rptr       (rptr)
  );

  rxf_store #(.ENTRIES(ENTRIES)) u_store (
    .clk      (clk),
    .we       (we),
    .wr_entry (wptr[EW+1:2]),
    .wr_lane  (wr_lane),
    .wr_byte  (wbyte),
    .rd_entry (rptr[EW+1:2]),
    .rd_half  (rd_half),
    .rd_word  (rd_data)
  );

  // R1: occupancy never exceeds capacity
  a_r1_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH_B));
  // R1: while full, a write and a read never both change the count the wrong way
  a_r1_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_fire) |=> (occ == PW'(DEPTH_B)));

endmodule

// File: tb/test_rx_endian_fifo.sv
module test_rx_endian_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int CAP = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic        cfg_empty_fill = 1'b0;
  logic [1:0]  cfg_thr_code = 2'd0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        eop_valid = 1'b0;
  logic [15:0] eop_status = 16'h0000;
  logic        dma_req;
  logic        dma_gnt = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic [5:0]  occupancy;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] q[$];
  int         qk[$];   // 0 data, 1 fill, 2 status
  bit         exp_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_endian_fifo i_rx_endian_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
    .cfg_empty_fill(cfg_empty_fill), .cfg_thr_code(cfg_thr_code),
    .in_valid(in_valid), .in_byte(in_byte), .eop_valid(eop_valid),
    .eop_status(eop_status), .dma_req(dma_req), .dma_gnt(dma_gnt),
    .rd_en(rd_en), .rd_data(rd_data), .occupancy(occupancy), .overflow(overflow)
  );

  function automatic int thr_of(input logic [1:0] code);
    int w;
    w = (code == 2'd0) ? 2 : (code == 2'd1) ? 4 : (code == 2'd2) ? 8 : 12;
    return (2 * w > CAP - 2) ? CAP - 2 : 2 * w;
  endfunction

  function automatic logic [15:0] word_of(input logic [7:0] first, input logic [7:0] second,
                                          input bit big);
    return big ? {first, second} : {second, first};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic void mpush(input logic [7:0] b, input int kind);
    if (q.size() < CAP) begin
      q.push_back(b);
      qk.push_back(kind);
    end else exp_ovf = 1'b1;
  endfunction

  task automatic do_reset(input bit big, input bit fill, input logic [1:0] code);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_big_endian = big;
    cfg_empty_fill = fill;
    cfg_thr_code = code;
    q.delete();
    qk.delete();
    exp_ovf = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R10 occupancy after reset", 32'(occupancy), 0);
    check("R10 dma_req after reset", 32'(dma_req), 0);
    check("R10 overflow after reset", 32'(overflow), 0);
  endtask

  task automatic push_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte = b;
      mpush(b, 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_eop(input logic [15:0] s);
    @(negedge clk);
    eop_valid = 1'b1;
    eop_status = s;
    if (q.size() % 2 == 1) mpush(8'hFF, 1);
    if (cfg_big_endian) begin mpush(s[15:8], 2); mpush(s[7:0], 2); end
    else begin mpush(s[7:0], 2); mpush(s[15:8], 2); end
    @(negedge clk);
    eop_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain();
    int thr;
    thr = thr_of(cfg_thr_code);
    @(negedge clk);
    for (int guard = 0; guard < 20; guard++) begin
      int n;
      int exp_n;
      check("R4 request versus threshold", 32'(dma_req), 32'(q.size() > thr));
      if (!dma_req) break;
      dma_gnt = 1'b1;
      exp_n = cfg_empty_fill ? q.size() / 2 : thr / 2;
      @(negedge clk);
      dma_gnt = 1'b0;
      n = 0;
      while (dma_req && n < 40) begin
        logic [15:0] ew;
        string tag;
        ew = word_of(q[0], q[1], cfg_big_endian);
        if (qk[0] == 2) tag = "R9 status word";
        else if (qk[1] == 1) tag = "R8 fill byte";
        else tag = cfg_big_endian ? "R3 big-endian word" : "R2 little-endian word";
        check(tag, 32'(rd_data), 32'(ew));
        void'(q.pop_front()); void'(q.pop_front());
        void'(qk.pop_front()); void'(qk.pop_front());
        rd_en = 1'b1;
        n++;
        @(negedge clk);
      end
      rd_en = 1'b0;
      check(cfg_empty_fill ? "R7 burst length (R11 drop)" : "R6 burst length (R11 drop)",
            32'(n), 32'(exp_n));
      check("R1 occupancy after burst", 32'(occupancy), 32'(q.size()));
      @(negedge clk);
    end
    check("R1 overflow flag", 32'(overflow), 32'(exp_ovf));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));

    // R4 threshold boundary: exactly 4 bytes gives no request, 5 gives one
    do_reset(1'b0, 1'b0, 2'd0);
    push_bytes(4);
    repeat (2) @(negedge clk);
    check("R4 no request at threshold", 32'(dma_req), 0);
    check("R1 occupancy count", 32'(occupancy), 4);
    push_bytes(1);
    drain();

    // R5 read strobe outside a burst is ignored; status mid-stream (R9)
    do_reset(1'b0, 1'b0, 2'd3);
    push_bytes(10);
    @(negedge clk);
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0;
    check("R5 rd_en outside burst keeps occupancy", 32'(occupancy), 10);
    send_eop(16'hC3A1);
    push_bytes(15);
    drain();

    // R8 R9 R3 odd packet, big-endian, empty-fill
    do_reset(1'b1, 1'b1, 2'd1);
    push_bytes(7);
    send_eop(16'hA55A);
    check("R8 occupancy with fill and status", 32'(occupancy), 10);
    drain();

    // R1 overflow: 35 bytes into 32 slots
    do_reset(1'b0, 1'b0, 2'd3);
    push_bytes(35);
    check("R1 occupancy when full", 32'(occupancy), 32);
    check("R1 overflow raised", 32'(overflow), 1);
    drain();

    // Random mix of modes, orders and packet lengths
    for (int it = 0; it < 40; it++) begin
      do_reset(1'($urandom), 1'($urandom), 2'($urandom));
      push_bytes($urandom_range(1, 20));
      send_eop(16'($urandom));
      if ($urandom_range(0, 1) == 1) begin
        push_bytes($urandom_range(0, 12));
        send_eop(16'($urandom));
      end
      drain();
    end

    finish_run();
  end

endmodule